// File: doc/BRIEF.md
# CAN Controller Interrupt Identifier Arbiter

This block gathers every interrupt source of a CAN controller and turns them into one prioritised identifier value and one interrupt line toward the CPU. The sources are per-message-object pending flags and a single status source. The message engine raises the message flags with one-cycle pulses. The status source is raised when the protocol engine reports receive, transmit, error-code or bus-error updates. The identifier always names the most urgent pending source. A bitmap output shows every pending message object at once, so software can pick whichever view it needs.

Software controls three enables through a small control write: one global line enable and two group enables for the status source. It acknowledges the status source by reading the status register. It retires a message interrupt through either of two clear paths: a message-control write, or a clear flag that accompanies a message read. The identifier is computed combinationally from registered state. Every set or clear therefore appears at the outputs in the cycle after its strobe.

Top module: `can_irq_arbiter`

## Requirements
- R1: With no status interrupt pending, `int_id` equals the number (1..32) of the lowest-numbered pending message object, regardless of arrival order; message number k is bit k-1 of `pend_map`.
- R2: A pulse on `msg_set[k-1]` makes message k pending from the next clock edge on, visible in `pend_map[k-1]`.
- R3: While the status interrupt is pending, `int_id` reads 0x8000 whatever message objects are pending.
- R4: With nothing pending, `int_id` reads 0x0000.
- R5: `irq` is high exactly when the global enable is set and `int_id` is nonzero; `int_id` and `pend_map` keep updating while the global enable is clear.
- R6: An `ev_rxok`, `ev_txok` or `ev_lec` pulse sets the status interrupt only when the status-group enable is set, and an `ev_err` pulse does so only when the error-group enable is set; the values carried need not differ from the stored ones.
- R7: The status interrupt is cleared only by `sts_rd`; `sts_wr` leaves it pending; an enabled status event in the same cycle as `sts_rd` keeps it pending.
- R8: `mctl_clr` with `mctl_num`=k, or `rdclr` with `rdclr_num`=k, clears message k at the next edge, and `int_id` moves to the next pending object; a same-cycle `msg_set` for k wins; numbers 0 or above 32 clear nothing.
- R9: `ctl_wr` loads the enables from `ctl_wdata`: bit 0 global, bit 1 status group, bit 2 error group; reset clears all enables, all pending flags and the status register.
- R10: `sts_q` bit 0 is receive-OK, bit 1 transmit-OK, bits 4:2 the last error code, bit 5 error warning, bit 6 bus-off. `ev_rxok`/`ev_txok` set bits 0/1, and `ev_lec` loads `lec_code`. `ev_err` loads `ewarn_in`/`boff_in`. `sts_wr` loads bits 4:0 from `sts_wdata`, with a same-cycle event taking precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Enables: {error group, status group, global} |
| ev_rxok | input | 1 | Receive-OK update pulse |
| ev_txok | input | 1 | Transmit-OK update pulse |
| ev_lec | input | 1 | Last-error-code update pulse |
| lec_code | input | 3 | Error code loaded by ev_lec |
| ev_err | input | 1 | Bus-off / warning update pulse |
| boff_in | input | 1 | Bus-off value loaded by ev_err |
| ewarn_in | input | 1 | Warning value loaded by ev_err |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 5 | Write data for status bits 4:0 |
| sts_rd | input | 1 | Status register read strobe |
| msg_set | input | 32 | Per-object pending set pulses |
| mctl_clr | input | 1 | Message-control clear strobe |
| mctl_num | input | 6 | Object number for mctl_clr |
| rdclr | input | 1 | Clear-on-message-read strobe |
| rdclr_num | input | 6 | Object number for rdclr |
| int_id | output | 16 | Highest-priority pending source identifier |
| pend_map | output | 32 | Pending message bitmap |
| sts_q | output | 7 | Status register contents |
| irq | output | 1 | Interrupt line to CPU |

## Verification
A corrupted pending flag or a lost status source shows at the ports one cycle after the stimulus that caused it. It appears as a wrong `int_id` or as a `pend_map` bit that differs from the reference. Wrong priority shows as an identifier naming a higher-numbered object while a lower one is set in `pend_map`. A broken clear path shows as an identifier that fails to advance in the cycle after the clear strobe. Because every cycle compares all four outputs against a behavioural model, a fault is reported on the first cycle where the state diverges. It does not wait for a later read.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  // Status register layout, MSB first: bit 6 down to bit 0
  typedef struct packed {
    logic       boff;
    logic       ewarn;
    logic [2:0] lec;
    logic       txok;
    logic       rxok;
  } sts_fields_t;

  localparam int STS_W = $bits(sts_fields_t);

  // Index of the lowest set bit, -1 when the vector is empty
  function automatic int lowest_set(input logic [63:0] v);
    int idx;
    idx = -1;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/msg_pend_bank.sv
module msg_pend_bank #(
  parameter int NUM_MSG = 32,
  parameter int NUM_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MSG-1:0] msg_set,
  input  logic               mctl_clr,
  input  logic [NUM_W-1:0]   mctl_num,
  input  logic               rdclr,
  input  logic [NUM_W-1:0]   rdclr_num,
  output logic [NUM_MSG-1:0] pend
);

  logic [NUM_MSG-1:0] clr_hit;

  for (genvar i = 0; i < NUM_MSG; i++) begin : g_obj
    localparam logic [NUM_W-1:0] OBJ_NUM = NUM_W'(i + 1);

    assign clr_hit[i] = (mctl_clr && (mctl_num == OBJ_NUM)) ||
                        (rdclr    && (rdclr_num == OBJ_NUM));

    always_ff @(posedge clk) begin
      if (!rst_n)          pend[i] <= 1'b0;
      else if (msg_set[i]) pend[i] <= 1'b1;
      else if (clr_hit[i]) pend[i] <= 1'b0;
    end

    // R2: a set pulse is seen in the next cycle
    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      msg_set[i] |=> pend[i]);

    // R8: a clear addressed to this object retires it unless set collides
    a_r8_clear_retires: assert property (@(posedge clk) disable iff (!rst_n)
      (((mctl_clr && mctl_num == OBJ_NUM) || (rdclr && rdclr_num == OBJ_NUM))
        && !msg_set[i]) |=> !pend[i]);

    // R8: without set or clear the flag holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!msg_set[i] && !clr_hit[i]) |=> $stable(pend[i]));
  end

endmodule

// File: rtl/stat_src.sv
module stat_src
  import can_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_ie,
  input  logic             err_ie,
  input  logic             ev_rxok,
  input  logic             ev_txok,
  input  logic             ev_lec,
  input  logic [2:0]       lec_code,
  input  logic             ev_err,
  input  logic             boff_in,
  input  logic             ewarn_in,
  input  logic             sts_wr,
  input  logic [4:0]       sts_wdata,
  input  logic             sts_rd,
  output logic [STS_W-1:0] sts_q,
  output logic             stat_pend
);

  sts_fields_t sts_r, sts_nx;
  logic        grp_stat_evt, grp_err_evt, stat_evt;

  assign grp_stat_evt = stat_ie && (ev_rxok || ev_txok || ev_lec);
  assign grp_err_evt  = err_ie && ev_err;
  assign stat_evt     = grp_stat_evt || grp_err_evt;

  always_comb begin
    sts_nx = sts_r;
    if (sts_wr) begin
      sts_nx.rxok = sts_wdata[0];
      sts_nx.txok = sts_wdata[1];
      sts_nx.lec  = sts_wdata[4:2];
    end
    if (ev_rxok) sts_nx.rxok = 1'b1;
    if (ev_txok) sts_nx.txok = 1'b1;
    if (ev_lec)  sts_nx.lec  = lec_code;
    if (ev_err) begin
      sts_nx.boff  = boff_in;
      sts_nx.ewarn = ewarn_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_r     <= '0;
      stat_pend <= 1'b0;
    end else begin
      sts_r <= sts_nx;
      if (stat_evt)    stat_pend <= 1'b1;
      else if (sts_rd) stat_pend <= 1'b0;
    end
  end

  assign sts_q = sts_r;

  // R7: only a read takes the status source away
  a_r7_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_pend && !sts_rd) |=> stat_pend);

  // R7: a read without a competing event clears it
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && !stat_ie && !err_ie) |=> !stat_pend);

  // R6: enabled status-group update raises the source
  a_r6_stat_group: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ie && (ev_rxok || ev_txok || ev_lec)) |=> stat_pend);

  // R6: disabled groups raise nothing
  a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_ie && !err_ie && !stat_pend) |=> !stat_pend);

endmodule

// File: rtl/id_select.sv
module id_select
  import can_irq_pkg::*;
#(
  parameter int                NUM_MSG   = 32,
  parameter int                ID_W      = 16,
  parameter logic [ID_W-1:0]   STATUS_ID = 16'h8000
) (
  input  logic               stat_pend,
  input  logic [NUM_MSG-1:0] pend,
  output logic [ID_W-1:0]    int_id
);

  int   win_idx;
  logic any_msg;

  always_comb begin
    win_idx = lowest_set(64'(pend));
    any_msg = |pend;
    if (stat_pend)    int_id = STATUS_ID;
    else if (any_msg) int_id = ID_W'(win_idx + 1);
    else              int_id = '0;
  end

endmodule

// File: rtl/can_irq_arbiter.sv
module can_irq_arbiter
  import can_irq_pkg::*;
#(
  parameter int              NUM_MSG   = 32,
  parameter int              ID_W      = 16,
  parameter logic [ID_W-1:0] STATUS_ID = 16'h8000,
  localparam int             NUM_W     = $clog2(NUM_MSG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic [2:0]         ctl_wdata,
  input  logic               ev_rxok,
  input  logic               ev_txok,
  input  logic               ev_lec,
  input  logic [2:0]         lec_code,
  input  logic               ev_err,
  input  logic               boff_in,
  input  logic               ewarn_in,
  input  logic               sts_wr,
  input  logic [4:0]         sts_wdata,
  input  logic               sts_rd,
  input  logic [NUM_MSG-1:0] msg_set,
  input  logic               mctl_clr,
  input  logic [NUM_W-1:0]   mctl_num,
  input  logic               rdclr,
  input  logic [NUM_W-1:0]   rdclr_num,
  output logic [ID_W-1:0]    int_id,
  output logic [NUM_MSG-1:0] pend_map,
  output logic [STS_W-1:0]   sts_q,
  output logic               irq
);

  logic glb_ie_q, stat_ie_q, err_ie_q;
  logic stat_pend;
  logic [NUM_MSG-1:0] pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_ie_q  <= 1'b0;
      stat_ie_q <= 1'b0;
      err_ie_q  <= 1'b0;
    end else if (ctl_wr) begin
      glb_ie_q  <= ctl_wdata[0];
      stat_ie_q <= ctl_wdata[1];
      err_ie_q  <= ctl_wdata[2];
    end
  end

  msg_pend_bank #(.NUM_MSG(NUM_MSG), .NUM_W(NUM_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .msg_set(msg_set),
    .mctl_clr(mctl_clr), .mctl_num(mctl_num),
    .rdclr(rdclr), .rdclr_num(rdclr_num), .pend(pend)
  );

  stat_src u_stat (
    .clk(clk), .rst_n(rst_n), .stat_ie(stat_ie_q), .err_ie(err_ie_q),
    .ev_rxok(ev_rxok), .ev_txok(ev_txok), .ev_lec(ev_lec), .lec_code(lec_code),
    .ev_err(ev_err), .boff_in(boff_in), .ewarn_in(ewarn_in),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_rd(sts_rd),
    .sts_q(sts_q), .stat_pend(stat_pend)
  );

  id_select #(.NUM_MSG(NUM_MSG), .ID_W(ID_W), .STATUS_ID(STATUS_ID)) u_sel (
    .stat_pend(stat_pend), .pend(pend), .int_id(int_id)
  );

  assign pend_map = pend;
  assign irq      = glb_ie_q && (int_id != '0);

  // Checker view: does int_id name a set bit with nothing set below it
  logic id_bit_set, id_below_clear;
  always_comb begin
    id_bit_set     = 1'b0;
    id_below_clear = 1'b1;
    for (int i = 0; i < NUM_MSG; i++) begin
      if (ID_W'(i + 1) == int_id && pend[i]) id_bit_set = 1'b1;
      if (ID_W'(i + 1) <  int_id && pend[i]) id_below_clear = 1'b0;
    end
  end

  a_r1_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_pend && (pend != '0)) |-> (id_bit_set && id_below_clear));

  a_r3_status_first: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pend |-> (int_id == STATUS_ID));

  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_pend && (pend == '0)) |-> (int_id == '0));

  a_r5_masked_line: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_ie_q |-> !irq);

endmodule

// File: tb/can_irq_arbiter_bench.sv
module can_irq_arbiter_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        ctl_wr;
  logic [2:0]  ctl_wdata;
  logic        ev_rxok, ev_txok, ev_lec, ev_err, boff_in, ewarn_in;
  logic [2:0]  lec_code;
  logic        sts_wr, sts_rd;
  logic [4:0]  sts_wdata;
  logic [31:0] msg_set;
  logic        mctl_clr, rdclr;
  logic [5:0]  mctl_num, rdclr_num;
  logic [15:0] int_id;
  logic [31:0] pend_map;
  logic [6:0]  sts_q;
  logic        irq;

  can_irq_arbiter u_can_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ev_rxok(ev_rxok), .ev_txok(ev_txok), .ev_lec(ev_lec), .lec_code(lec_code),
    .ev_err(ev_err), .boff_in(boff_in), .ewarn_in(ewarn_in),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_rd(sts_rd),
    .msg_set(msg_set), .mctl_clr(mctl_clr), .mctl_num(mctl_num),
    .rdclr(rdclr), .rdclr_num(rdclr_num),
    .int_id(int_id), .pend_map(pend_map), .sts_q(sts_q), .irq(irq)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // ---------------- behavioural reference ----------------
  bit m_pend[1:32];
  bit m_stat, m_glb, m_sie, m_eie, m_rx, m_tx, m_boff, m_warn;
  int m_lec;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pend[k]) m_pend[k] = 0;
      {m_stat, m_glb, m_sie, m_eie, m_rx, m_tx, m_boff, m_warn} = '0;
      m_lec = 0;
    end else begin
      bit raise;
      raise = (m_sie && (ev_rxok || ev_txok || ev_lec)) || (m_eie && ev_err);
      if (raise) m_stat = 1;
      else if (sts_rd) m_stat = 0;
      if (sts_wr) begin
        m_rx = sts_wdata[0]; m_tx = sts_wdata[1]; m_lec = sts_wdata[4:2];
      end
      if (ev_rxok) m_rx = 1;
      if (ev_txok) m_tx = 1;
      if (ev_lec) m_lec = lec_code;
      if (ev_err) begin m_boff = boff_in; m_warn = ewarn_in; end
      if (ctl_wr) begin
        m_glb = ctl_wdata[0]; m_sie = ctl_wdata[1]; m_eie = ctl_wdata[2];
      end
      for (int k = 1; k <= 32; k++) begin
        if (msg_set[k-1]) m_pend[k] = 1;
        else if ((mctl_clr && mctl_num == k) || (rdclr && rdclr_num == k)) m_pend[k] = 0;
      end
    end
  end

  function automatic int exp_id();
    if (m_stat) return 32'h8000;
    for (int k = 1; k <= 32; k++) if (m_pend[k]) return k;
    return 0;
  endfunction

  function automatic logic [31:0] exp_map();
    logic [31:0] v = '0;
    for (int k = 1; k <= 32; k++) v[k-1] = m_pend[k];
    return v;
  endfunction

  function automatic logic [6:0] exp_sts();
    return {m_boff, m_warn, 3'(m_lec), m_tx, m_rx};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, outputs depend only on registered state
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1/R3/R4 int_id model", 32'(int_id), 32'(exp_id()));
      chk("R2/R8 pend_map model", pend_map, exp_map());
      chk("R10 sts_q model", 32'(sts_q), 32'(exp_sts()));
      chk("R5 irq model", 32'(irq), 32'(m_glb && exp_id() != 0));
    end
  end

  task automatic quiet();
    ctl_wr = 0; ctl_wdata = 0; ev_rxok = 0; ev_txok = 0; ev_lec = 0;
    lec_code = 0; ev_err = 0; boff_in = 0; ewarn_in = 0; sts_wr = 0;
    sts_wdata = 0; sts_rd = 0; msg_set = 0; mctl_clr = 0; mctl_num = 0;
    rdclr = 0; rdclr_num = 0;
  endtask

  // inputs were set after a negedge; let one edge take them, then idle
  task automatic step();
    @(negedge clk);
    quiet();
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    quiet();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset int_id", 32'(int_id), 0);
    chk("R9 reset pend_map", pend_map, 0);
    chk("R9 reset irq", 32'(irq), 0);
    chk("R9 reset sts_q", 32'(sts_q), 0);

    // R1 R2: objects 9 then 5, lowest wins
    msg_set[8] = 1; step();
    msg_set[4] = 1; step();
    chk("R1 lowest object", 32'(int_id), 5);
    chk("R2 bitmap", pend_map, 32'h110);
    chk("R5 line masked, id live", 32'(irq), 0);

    ctl_wr = 1; ctl_wdata = 3'b001; step();
    chk("R9 R5 global enable raises irq", 32'(irq), 1);

    ev_rxok = 1; step();
    chk("R6 rx update masked", 32'(int_id), 5);
    chk("R10 rxok bit", 32'(sts_q), 32'h01);

    ctl_wr = 1; ctl_wdata = 3'b011; step();
    ev_txok = 1; step();
    chk("R3 status outranks objects", 32'(int_id), 32'h8000);

    sts_wr = 1; sts_wdata = 5'b0; step();
    chk("R10 write clears low bits", 32'(sts_q), 0);
    chk("R7 write keeps source", 32'(int_id), 32'h8000);

    sts_rd = 1; step();
    chk("R7 read clears source", 32'(int_id), 5);

    mctl_clr = 1; mctl_num = 5; step();
    chk("R8 control clear advances", 32'(int_id), 9);

    rdclr = 1; rdclr_num = 9; msg_set[8] = 1; step();
    chk("R8 set beats clear", 32'(int_id), 9);
    rdclr = 1; rdclr_num = 9; step();
    chk("R4 idle zero", 32'(int_id), 0);
    chk("R5 irq drops", 32'(irq), 0);

    ctl_wr = 1; ctl_wdata = 3'b001; step();
    ev_err = 1; boff_in = 1; step();
    chk("R6 error update masked", 32'(int_id), 0);
    ctl_wr = 1; ctl_wdata = 3'b101; step();
    ev_err = 1; boff_in = 1; step();
    chk("R6 unchanged value still raises", 32'(int_id), 32'h8000);
    chk("R10 bus-off bit", 32'(sts_q), 32'h40);
    sts_rd = 1; ev_err = 1; boff_in = 1; step();
    chk("R7 event during read wins", 32'(int_id), 32'h8000);
    sts_rd = 1; step();
    chk("R7 plain read clears", 32'(int_id), 0);

    msg_set[31] = 1; msg_set[0] = 1; step();
    chk("R1 object 1", 32'(int_id), 1);
    mctl_clr = 1; mctl_num = 0; rdclr = 1; rdclr_num = 33; step();
    chk("R8 out-of-range clears nothing", pend_map, 32'h8000_0001);
    rdclr = 1; rdclr_num = 1; step();
    chk("R8 next object 32", 32'(int_id), 32);
    ctl_wr = 1; ctl_wdata = 3'b000; step();
    chk("R5 mask with id nonzero", 32'(irq), 0);

    // random traffic checked against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      ctl_wr    = ($urandom % 16) == 0;
      ctl_wdata = 3'($urandom);
      ev_rxok   = ($urandom % 8) == 0;
      ev_txok   = ($urandom % 8) == 0;
      ev_lec    = ($urandom % 8) == 0;
      lec_code  = 3'($urandom);
      ev_err    = ($urandom % 10) == 0;
      boff_in   = 1'($urandom);
      ewarn_in  = 1'($urandom);
      sts_wr    = ($urandom % 10) == 0;
      sts_wdata = 5'($urandom);
      sts_rd    = ($urandom % 5) == 0;
      msg_set   = $urandom & $urandom & $urandom & $urandom;
      mctl_clr  = ($urandom % 2) == 0;
      mctl_num  = 6'($urandom % 36);
      rdclr     = ($urandom % 2) == 0;
      rdclr_num = 6'($urandom % 36);
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule